// File: doc/BRIEF.md
# IPv6 Route Lookup Walker

This block resolves a 128-bit IPv6 destination address to a 9-bit next-hop identifier. It walks a compressed multi-level trie held in a word-addressed table memory, one level per read. The three leading format bits and the 64-bit interface identifier play no part in the search. The first level is a direct table of 2^15 entries. Each entry carries a 64-bit occupancy bitmap plus either up to four inline next-hop words or a pointer to an overflow list. Each deeper level is a 16-entry node reached through a pointer. Its entries carry a 16-bit bitmap plus either up to three inline next-hop words or an overflow pointer.

A next-hop word with bit 15 clear ends the walk. In that case bits 14:6 give the next-hop ID and bits 5:0 give the prefix length. A word with bit 15 set holds a 15-bit pointer in bits 14:0. Below the fourth level, that pointer goes to an external hashed long-prefix engine. The walker has one lookup in flight at a time and uses a pulse-request memory port whose latency is not fixed.

Top module: `v6_route_walker`

## Requirements
- R1: While reset is held, busy, done, mem_req and hash_req are 0, and next_hop_id, prefix_len, miss and mem_accesses are 0.
- R2: When start is sampled while the walker is idle, busy and mem_req are 1 in the next cycle. The first read goes to word address equal to address bits 124:110.
- R3: At the first level, address bits 109:104 pick a bitmap bit, and rank is the count of set bits from bit 0 up to and including that bit. The first-level memory word holds the bitmap in bits 127:64. When the bitmap has at most 4 set bits, the result is the inline word at payload bits [16*rank-1 : 16*(rank-1)] of bits 63:0.
- R4: A selected word with bit 15 clear completes the lookup. done is high for exactly one cycle, next_hop_id = word[14:6], prefix_len = word[5:0], and miss = 0.
- R5: A rank of 0 completes the lookup with miss = 1 and next_hop_id = prefix_len = 0.
- R6: When a node has more set bits than it can hold inline (4 at the first level, 3 deeper), one extra read goes to pointer + rank - 1. The pointer is bits 63:32 of the first-level word, or bits 31:0 of a deeper word. The selected word is bits 15:0 of that read.
- R7: A word with bit 15 set below the fourth level reads word address 2^19 + {word[14:0], n}. Here n is address bits 103:100, 95:92 or 87:84 for levels 2, 3 and 4. The bitmap position is bits 99:96, 91:88 or 83:80. A deeper word holds the bitmap in bits 63:48 and inline words in bits 47:0.
- R8: A pointer word at the fourth level raises hash_req for one cycle with hash_key = address bits 124:64 and hash_ptr = word[14:0]. A reply with bit 15 clear is a hit decoded as in R4, and a reply with bit 15 set is a miss.
- R9: mem_accesses equals the number of reads issued for the lookup, which is at most 8.
- R10: busy stays 1 from the cycle after start until done. A start during that time is ignored. No read is issued while a response is pending.
- R11: Address bits 127:125 and 63:0 have no effect on the result.
- R12: Results do not depend on memory response latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a lookup (honoured when idle) |
| dst_addr | input | 128 | Destination address |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle completion pulse |
| next_hop_id | output | 9 | Resolved next-hop ID |
| prefix_len | output | 6 | Length of matched prefix |
| miss | output | 1 | No route matched |
| mem_accesses | output | 4 | Reads used by the last lookup |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | ADDR_W | Read word address |
| mem_resp_valid | input | 1 | Read data valid |
| mem_rdata | input | 128 | Read data |
| hash_req | output | 1 | One-cycle long-prefix request |
| hash_key | output | 61 | Address bits 124:64 |
| hash_ptr | output | 15 | Pointer from fourth-level word |
| hash_resp_valid | input | 1 | Hash reply valid |
| hash_word | input | 16 | Hash reply next-hop word |

## Verification
busy and the first mem_req are due in the cycle after start is sampled. Each later read follows one or two cycles after the previous response: two when a node must be resolved from its bitmap, one when the word arrives from an overflow list. done appears one cycle after the deciding word. The bench's memory and hash models count their latency at the falling edge and sample every output there, so each comparison sees settled registers. The bench also waits on done rather than a fixed cycle count, which lets the same checks hold under several latencies.

// File: rtl/v6rw_pkg.sv
`timescale 1ns/1ps
package v6rw_pkg;
    localparam int NHI_W     = 16;
    localparam int HOP_W     = 9;
    localparam int PLEN_W    = 6;
    localparam int L1_IDX_W  = 15;
    localparam int BM_W      = 64;
    localparam int POS_W     = $clog2(BM_W);
    localparam int RANK_W    = POS_W + 1;
    localparam int L1_SLOTS  = 4;
    localparam int LN_SLOTS  = 3;
    localparam int MAX_LEVEL = 4;
    localparam int LVL_W     = 3;
    localparam int KEY_W     = 61;

    typedef enum logic [2:0] {
        S_IDLE, S_L1_READ, S_RESOLVE, S_OVF_READ, S_LN_READ, S_HASH_REQ, S_DONE
    } walk_state_e;

    typedef struct packed {
        logic            is_l1;
        logic [BM_W-1:0] bitmap;
        logic [63:0]     payload;
    } trie_entry_t;

    // index nibble [7:4] and bitmap nibble [3:0] for a deeper level (2..4)
    function automatic logic [7:0] level_nibbles(input logic [23:0] sub,
                                                 input logic [LVL_W-1:0] lvl);
        logic [23:0] t;
        if (lvl < 3'd2) t = sub;
        else            t = sub << (8 * (int'(lvl) - 2));
        return t[23:16];
    endfunction
endpackage

// File: rtl/v6rw_rank.sv
`timescale 1ns/1ps
module v6rw_rank #(
    parameter  int W  = 64,
    localparam int PW = $clog2(W),
    localparam int CW = PW + 1
) (
    input  logic [W-1:0]  bits,
    input  logic [PW-1:0] pos,
    output logic [CW-1:0] rank,
    output logic [CW-1:0] total
);
    logic [W-1:0] mask;

    always_comb begin
        mask  = {W{1'b1}} >> (PW'(W - 1) - pos);
        rank  = '0;
        total = '0;
        for (int i = 0; i < W; i++) begin
            rank  = rank  + CW'(bits[i] & mask[i]);
            total = total + CW'(bits[i]);
        end
    end
endmodule

// File: rtl/v6rw_slot_pick.sv
`timescale 1ns/1ps
module v6rw_slot_pick import v6rw_pkg::*; #(
    parameter int ADDR_W = 20
) (
    input  trie_entry_t        entry,
    input  logic [RANK_W-1:0]  rank,
    input  logic [RANK_W-1:0]  total,
    output logic               inline_ok,
    output logic [NHI_W-1:0]   slot_word,
    output logic [ADDR_W-1:0]  ovf_addr
);
    logic [1:0]        sel;
    logic [63:0]       shifted;
    logic [ADDR_W-1:0] base;

    always_comb begin
        inline_ok = entry.is_l1 ? (total <= RANK_W'(L1_SLOTS))
                                : (total <= RANK_W'(LN_SLOTS));
        sel       = rank[1:0] - 2'd1;
        shifted   = entry.payload >> {sel, 4'b0000};
        slot_word = shifted[NHI_W-1:0];
        base      = entry.is_l1 ? entry.payload[32 +: ADDR_W]
                                : entry.payload[0 +: ADDR_W];
        ovf_addr  = base + ADDR_W'(rank) - ADDR_W'(1);
    end
endmodule

// File: rtl/v6_route_walker.sv
`timescale 1ns/1ps
module v6_route_walker import v6rw_pkg::*; #(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [127:0]       dst_addr,
    output logic               busy,
    output logic               done,
    output logic [HOP_W-1:0]   next_hop_id,
    output logic [PLEN_W-1:0]  prefix_len,
    output logic               miss,
    output logic [CNT_W-1:0]   mem_accesses,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_resp_valid,
    input  logic [127:0]       mem_rdata,
    output logic               hash_req,
    output logic [KEY_W-1:0]   hash_key,
    output logic [14:0]        hash_ptr,
    input  logic               hash_resp_valid,
    input  logic [NHI_W-1:0]   hash_word
);
    localparam logic [ADDR_W-1:0] LN_BASE = ADDR_W'(1) << (ADDR_W - 1);

    walk_state_e        state;
    logic [KEY_W-1:0]   key_q;      // address bits 124:64
    logic [LVL_W-1:0]   level_q;
    trie_entry_t        entry_q;

    logic [RANK_W-1:0]  rank, total;
    logic [POS_W-1:0]   cur_pos;
    logic [7:0]         nib_cur, nib_next;
    logic               inline_ok;
    logic [NHI_W-1:0]   slot_word, cur_word;
    logic [ADDR_W-1:0]  ovf_addr, ln_addr;

    always_comb begin
        nib_cur  = level_nibbles(key_q[39:16], level_q);
        nib_next = level_nibbles(key_q[39:16], LVL_W'(level_q + 3'd1));
        cur_pos  = (level_q == 3'd1) ? key_q[45:40] : {2'b00, nib_cur[3:0]};
        cur_word = (state == S_OVF_READ) ? mem_rdata[NHI_W-1:0] : slot_word;
        ln_addr  = LN_BASE + ADDR_W'({cur_word[14:0], nib_next[7:4]});
    end

    v6rw_rank #(.W(BM_W)) u_rank (
        .bits  (entry_q.bitmap),
        .pos   (cur_pos),
        .rank  (rank),
        .total (total)
    );

    v6rw_slot_pick #(.ADDR_W(ADDR_W)) u_pick (
        .entry     (entry_q),
        .rank      (rank),
        .total     (total),
        .inline_ok (inline_ok),
        .slot_word (slot_word),
        .ovf_addr  (ovf_addr)
    );

    assign busy     = (state != S_IDLE) && (state != S_DONE);
    assign done     = (state == S_DONE);
    assign hash_key = key_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= S_IDLE;
            key_q        <= '0;
            level_q      <= 3'd1;
            entry_q      <= '0;
            next_hop_id  <= '0;
            prefix_len   <= '0;
            miss         <= 1'b0;
            mem_accesses <= '0;
            mem_req      <= 1'b0;
            mem_addr     <= '0;
            hash_req     <= 1'b0;
            hash_ptr     <= '0;
        end else begin
            mem_req  <= 1'b0;
            hash_req <= 1'b0;
            unique case (state)
                S_IDLE: if (start) begin
                    key_q        <= dst_addr[124:64];
                    level_q      <= 3'd1;
                    next_hop_id  <= '0;
                    prefix_len   <= '0;
                    miss         <= 1'b0;
                    mem_req      <= 1'b1;
                    mem_addr     <= ADDR_W'(dst_addr[124:110]);
                    mem_accesses <= CNT_W'(1);
                    state        <= S_L1_READ;
                end
                S_L1_READ, S_LN_READ: if (mem_resp_valid) begin
                    entry_q.is_l1 <= (state == S_L1_READ);
                    if (state == S_L1_READ) begin
                        entry_q.bitmap  <= mem_rdata[127:64];
                        entry_q.payload <= mem_rdata[63:0];
                    end else begin
                        entry_q.bitmap  <= {48'b0, mem_rdata[63:48]};
                        entry_q.payload <= {16'b0, mem_rdata[47:0]};
                    end
                    state <= S_RESOLVE;
                end
                S_RESOLVE, S_OVF_READ: begin
                    if (state == S_RESOLVE && rank == '0) begin
                        miss  <= 1'b1;
                        state <= S_DONE;
                    end else if (state == S_RESOLVE && !inline_ok) begin
                        mem_req      <= 1'b1;
                        mem_addr     <= ovf_addr;
                        mem_accesses <= mem_accesses + CNT_W'(1);
                        state        <= S_OVF_READ;
                    end else if (state == S_RESOLVE || mem_resp_valid) begin
                        if (!cur_word[15]) begin
                            next_hop_id <= cur_word[14:6];
                            prefix_len  <= cur_word[5:0];
                            state       <= S_DONE;
                        end else if (level_q < LVL_W'(MAX_LEVEL)) begin
                            level_q      <= LVL_W'(level_q + 3'd1);
                            mem_req      <= 1'b1;
                            mem_addr     <= ln_addr;
                            mem_accesses <= mem_accesses + CNT_W'(1);
                            state        <= S_LN_READ;
                        end else begin
                            hash_req <= 1'b1;
                            hash_ptr <= cur_word[14:0];
                            state    <= S_HASH_REQ;
                        end
                    end
                end
                S_HASH_REQ: if (hash_resp_valid) begin
                    if (!hash_word[15]) begin
                        next_hop_id <= hash_word[14:6];
                        prefix_len  <= hash_word[5:0];
                    end else begin
                        miss <= 1'b1;
                    end
                    state <= S_DONE;
                end
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/v6rw_walk_chk.sv
`timescale 1ns/1ps
module v6rw_walk_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             miss,
    input logic [8:0]       next_hop_id,
    input logic [5:0]       prefix_len,
    input logic [CNT_W-1:0] mem_accesses,
    input logic             mem_req,
    input logic             mem_resp_valid,
    input logic             hash_req
);
    logic pend;

    always_ff @(posedge clk) begin
        if (rst)                 pend <= 1'b0;
        else if (mem_resp_valid) pend <= 1'b0;
        else if (mem_req)        pend <= 1'b1;
    end

    assert_start_launch_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !done) |=> (busy && mem_req));

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_miss_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (done && miss) |-> (next_hop_id == 9'd0 && prefix_len == 6'd0));

    assert_hash_depth_R8: assert property (@(posedge clk) disable iff (rst)
        hash_req |-> (busy && mem_accesses >= CNT_W'(4)));

    assert_read_bound_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (mem_accesses <= CNT_W'(8)));

    assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (!pend && busy));

    assert_busy_done_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));
endmodule

bind v6_route_walker v6rw_walk_chk #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .start          (start),
    .busy           (busy),
    .done           (done),
    .miss           (miss),
    .next_hop_id    (next_hop_id),
    .prefix_len     (prefix_len),
    .mem_accesses   (mem_accesses),
    .mem_req        (mem_req),
    .mem_resp_valid (mem_resp_valid),
    .hash_req       (hash_req)
);

// File: tb/v6_route_walker_tb.sv
`timescale 1ns/1ps
module v6_route_walker_tb;
    localparam int ADDR_W = 20;
    localparam int LNB    = 32'h80000;

    logic clk = 1'b0;
    logic rst, start;
    logic [127:0] dst_addr;
    logic busy, done, miss, mem_req, mem_resp_valid, hash_req, hash_resp_valid;
    logic [8:0] next_hop_id;
    logic [5:0] prefix_len;
    logic [3:0] mem_accesses;
    logic [ADDR_W-1:0] mem_addr;
    logic [127:0] mem_rdata;
    logic [60:0] hash_key;
    logic [14:0] hash_ptr;
    logic [15:0] hash_word;

    always #2.5 clk = ~clk;

    v6_route_walker #(.ADDR_W(ADDR_W), .CNT_W(4)) u_dut (
        .clk(clk), .rst(rst), .start(start), .dst_addr(dst_addr),
        .busy(busy), .done(done), .next_hop_id(next_hop_id),
        .prefix_len(prefix_len), .miss(miss), .mem_accesses(mem_accesses),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_resp_valid(mem_resp_valid), .mem_rdata(mem_rdata),
        .hash_req(hash_req), .hash_key(hash_key), .hash_ptr(hash_ptr),
        .hash_resp_valid(hash_resp_valid), .hash_word(hash_word)
    );

    int checks = 0, failures = 0;
    logic [127:0] mem [int];
    int lat = 2;
    int cd = 0, hcd = 0, nreq = 0, nhash = 0;
    logic [ADDR_W-1:0] pend_a;
    logic [ADDR_W-1:0] req_log [$];
    logic [15:0] hash_reply = 16'h0;
    logic [60:0] seen_key;
    logic [14:0] seen_hptr;
    logic [8:0] got_id;
    logic [5:0] got_len;
    logic got_miss;
    logic [3:0] got_cnt;
    logic busy_gap;

    function automatic logic [127:0] fetch(input logic [ADDR_W-1:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : 128'h0;
    endfunction

    function automatic logic [15:0] term(input int id, input int len);
        return {1'b0, 9'(id), 6'(len)};
    endfunction

    function automatic logic [15:0] ptrw(input int p);
        return {1'b1, 15'(p)};
    endfunction

    function automatic logic [127:0] mkaddr(input logic [2:0] fp, input logic [14:0] idx,
            input logic [5:0] pos, input logic [3:0] i2, input logic [3:0] p2,
            input logic [3:0] i3, input logic [3:0] p3, input logic [3:0] i4,
            input logic [3:0] p4, input logic [15:0] tail, input logic [63:0] low);
        return {fp, idx, pos, i2, p2, i3, p3, i4, p4, tail, low};
    endfunction

    task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    // memory responder: latency counted in falling edges
    initial begin
        mem_resp_valid = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            mem_resp_valid = 1'b0;
            if (cd > 0) begin
                cd--;
                if (cd == 0) begin
                    mem_resp_valid = 1'b1;
                    mem_rdata = fetch(pend_a);
                end
            end
            if (!rst && mem_req) begin
                pend_a = mem_addr;
                req_log.push_back(mem_addr);
                nreq++;
                if (lat <= 1) begin
                    mem_resp_valid = 1'b1;
                    mem_rdata = fetch(mem_addr);
                end else cd = lat - 1;
            end
        end
    end

    // hash responder
    initial begin
        hash_resp_valid = 1'b0;
        hash_word = '0;
        forever begin
            @(negedge clk);
            hash_resp_valid = 1'b0;
            if (hcd > 0) begin
                hcd--;
                if (hcd == 0) begin
                    hash_resp_valid = 1'b1;
                    hash_word = hash_reply;
                end
            end
            if (!rst && hash_req) begin
                seen_key = hash_key;
                seen_hptr = hash_ptr;
                nhash++;
                hcd = 2;
            end
        end
    end

    task automatic wait_done();
        int cyc = 0;
        busy_gap = 1'b0;
        while (!done && cyc < 3000) begin
            if (!busy) busy_gap = 1'b1;
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            failures++;
            $display("FAIL R10 actual=no_done expected=done");
        end
        got_id = next_hop_id;
        got_len = prefix_len;
        got_miss = miss;
        got_cnt = mem_accesses;
    endtask

    task automatic run_lookup(input logic [127:0] a);
        req_log.delete();
        nreq = 0;
        nhash = 0;
        @(negedge clk);
        start = 1'b1;
        dst_addr = a;
        @(negedge clk);
        start = 1'b0;
        wait_done();
    endtask

    task automatic t_reset();
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 mem_req", mem_req, 0);
        check("R1 hash_req", hash_req, 0);
        check("R1 outputs", {next_hop_id, prefix_len, miss, mem_accesses}, 0);
    endtask

    task automatic t_l1_inline();
        mem[9] = {64'h0000_0000_0010_0021, 16'h0, term(300, 24), term(77, 20), term(1, 18)};
        run_lookup(mkaddr(3'b001, 15'd9, 6'd12, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 16'h0, 64'h0));
        check("R2 first addr", req_log[0], 20'd9);
        check("R3 R4 hop rank2", got_id, 77);
        check("R4 plen", got_len, 20);
        check("R4 miss", got_miss, 0);
        check("R9 count1", got_cnt, 1);
        check("R10 busy held", busy_gap, 0);
        run_lookup(mkaddr(3'b001, 15'd9, 6'd25, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 16'h0, 64'h0));
        check("R3 hop rank3", got_id, 300);
        run_lookup(mkaddr(3'b001, 15'd9, 6'd3, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 16'h0, 64'h0));
        check("R3 hop rank1", got_id, 1);
        run_lookup(mkaddr(3'b001, 15'd9, 6'd63, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 16'h0, 64'h0));
        check("R3 hop pos63", got_id, 300);
    endtask

    task automatic t_miss();
        mem[10] = {64'h400, 48'h0, term(5, 5)};
        run_lookup(mkaddr(3'b001, 15'd10, 6'd3, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 16'h0, 64'h0));
        check("R5 miss", got_miss, 1);
        check("R5 hop zero", {got_id, got_len}, 0);
        check("R9 miss count", got_cnt, 1);
    endtask

    task automatic t_l1_overflow();
        mem[100] = {64'h3F, 32'h0003_0000, 32'h0};
        mem[32'h30004] = {112'h0, term(123, 30)};
        run_lookup(mkaddr(3'b001, 15'd100, 6'd4, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 16'h0, 64'h0));
        check("R6 ovf addr", req_log[1], 20'h30004);
        check("R6 ovf hop", {got_id, got_len}, {9'd123, 6'd30});
        check("R9 ovf count", got_cnt, 2);
    endtask

    task automatic t_multilevel();
        run_lookup(mkaddr(3'b001, 15'd200, 6'd7, 4'd3, 4'd10, 4'd7, 4'd5, 4'h0, 4'h0, 16'h0, 64'h0));
        check("R7 l2 addr", req_log[1], 20'h80053);
        check("R7 l3 addr", req_log[2], 20'h80067);
        check("R7 hop", {got_id, got_len}, {9'd411, 6'd40});
        check("R9 ml count", got_cnt, 3);
    endtask

    task automatic t_hash();
        logic [127:0] a;
        mem[300] = {64'h1, 48'h0, ptrw(8)};
        mem[32'h80081] = {64'h0, 16'h0001, 32'h0, ptrw(9)};
        mem[32'h80092] = {64'h0, 16'h0001, 32'h0, ptrw(10)};
        mem[32'h800A4] = {64'h0, 16'h0001, 32'h0, ptrw(11)};
        a = mkaddr(3'b001, 15'd300, 6'd0, 4'd1, 4'd0, 4'd2, 4'd0, 4'd4, 4'd0, 16'hBEEF, 64'h0);
        hash_reply = term(222, 56);
        run_lookup(a);
        check("R8 hash_ptr", seen_hptr, 11);
        check("R8 hash_key", seen_key, a[124:64]);
        check("R8 one hash", nhash, 1);
        check("R8 hit", {got_miss, got_id, got_len}, {1'b0, 9'd222, 6'd56});
        check("R9 hash count", got_cnt, 4);
        hash_reply = 16'h8001;
        run_lookup(a);
        check("R8 hash miss", {got_miss, got_id}, {1'b1, 9'd0});
    endtask

    task automatic t_worst();
        mem[400] = {64'hFFFF_FFFF_FFFF_FFFF, 32'h0003_1000, 32'h0};
        mem[32'h31000] = {112'h0, ptrw(12)};
        mem[32'h800C5] = {64'h0, 16'hFFFF, 16'h0, 32'h0003_2000};
        mem[32'h32002] = {112'h0, ptrw(13)};
        mem[32'h800D6] = {64'h0, 16'hFFFF, 16'h0, 32'h0003_3000};
        mem[32'h3300F] = {112'h0, ptrw(14)};
        mem[32'h800E0] = {64'h0, 16'hFFFF, 16'h0, 32'h0003_4000};
        mem[32'h34000] = {112'h0, term(99, 48)};
        run_lookup(mkaddr(3'b001, 15'd400, 6'd0, 4'd5, 4'd2, 4'd6, 4'd15, 4'd0, 4'd0, 16'h0, 64'h0));
        check("R9 worst count", got_cnt, 8);
        check("R9 worst reqs", nreq, 8);
        check("R6 deep ovf addr", req_log[5], 20'h3300F);
        check("R7 l4 addr", req_log[6], 20'h800E0);
        check("R6 worst hop", {got_id, got_len}, {9'd99, 6'd48});
    endtask

    task automatic t_ignored_bits();
        run_lookup(mkaddr(3'b111, 15'd9, 6'd12, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 16'h0,
                          64'hDEAD_BEEF_0123_4567));
        check("R11 first addr", req_log[0], 20'd9);
        check("R11 same hop", {got_id, got_len, got_miss}, {9'd77, 6'd20, 1'b0});
    endtask

    task automatic t_latency();
        lat = 7;
        run_lookup(mkaddr(3'b001, 15'd200, 6'd7, 4'd3, 4'd10, 4'd7, 4'd5, 4'h0, 4'h0, 16'h0, 64'h0));
        check("R12 slow hop", {got_id, got_len}, {9'd411, 6'd40});
        check("R12 slow count", got_cnt, 3);
        lat = 1;
        run_lookup(mkaddr(3'b001, 15'd100, 6'd4, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 16'h0, 64'h0));
        check("R12 fast hop", got_id, 123);
        lat = 2;
    endtask

    task automatic t_busy_start();
        lat = 6;
        req_log.delete();
        nreq = 0;
        @(negedge clk);
        start = 1'b1;
        dst_addr = mkaddr(3'b001, 15'd200, 6'd7, 4'd3, 4'd10, 4'd7, 4'd5, 4'h0, 4'h0, 16'h0, 64'h0);
        @(negedge clk);
        start = 1'b0;
        check("R2 busy next", busy, 1);
        check("R2 req next", mem_req, 1);
        repeat (3) @(negedge clk);
        check("R10 busy mid", busy, 1);
        start = 1'b1;
        dst_addr = mkaddr(3'b001, 15'd9, 6'd12, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 16'h0, 64'h0);
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check("R10 first kept", got_id, 411);
        check("R10 req count", nreq, 3);
        check("R10 busy held", busy_gap, 0);
        @(negedge clk);
        check("R4 done pulse", {done, busy}, 2'b00);
        lat = 2;
    endtask

    initial begin
        #(5.0 * 100000);
        failures++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1;
        start = 1'b0;
        dst_addr = '0;
        mem[200] = {64'h1, 48'h0, ptrw(5)};
        mem[32'h80053] = {64'h0, 16'h0101, 16'h0, ptrw(6), term(1, 1)};
        mem[32'h80067] = {64'h0, 16'h0001, 32'h0, term(411, 40)};
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_l1_inline();
        t_miss();
        t_l1_overflow();
        t_multilevel();
        t_hash();
        t_worst();
        t_ignored_bits();
        t_latency();
        t_busy_start();
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule